// File: doc/BRIEF.md
# Serial Configuration Write Slave

This block is a write-only serial slave for a two-wire bus. It gives the clock-control logic of a clock generator its settings. It watches the open-drain clock and data lines and oversamples them with the fast system clock. It detects START and STOP conditions and matches a fixed 7-bit device address. After a match it acknowledges every following byte. A transaction has three parts in a fixed order:
- a command code, which the block acknowledges and otherwise ignores;
- a byte count, which it also acknowledges and ignores;
- data bytes, which it stores in a small bank of configuration registers, starting at register 0.

The block never holds the clock low, so every byte completes at the controller's pace. It keeps data bytes only while the bank has room. Later bytes are still acknowledged, but they are dropped. A `transfer valid` flag rises once the byte count has been acknowledged.

An active-low power-down input makes the block treat both lines as tri-stated. While it is asserted, the data line is released and all bus activity is ignored. The register bank keeps its contents. An optional three-sample glitch filter on each line rejects short noise pulses.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The first byte after a START is sampled MSB first on rising clock edges. If its upper seven bits equal `DEV_ADDR` (default 7'h69) and its LSB is 0 (write), the block acknowledges it.
- R2: The block does not acknowledge an address byte that has a different address, the read bit (LSB 1), or the all-zero general-call address. It then drives no acknowledge and writes no register until the next START.
- R3: After a matched address, every byte is acknowledged. `sdaOe` goes high only after the clock falls at the end of the 8th bit, and it goes low at the clock fall that ends the 9th bit.
- R4: The command-code and byte-count bytes are not stored. Data bytes go into consecutive registers starting at register 0. Register k appears on `cfgRegs[8k+7:8k]`.
- R5: Data bytes beyond `NUM_REGS` (default 4) are acknowledged but discarded. All registers keep their values.
- R6: `xferValid` is 0 after reset. It becomes 1 at the clock fall that ends the acknowledge of the byte-count byte. Any START clears it.
- R7: A repeated START or a STOP returns the block to address matching. Registers written earlier stay written. The next transaction writes from register 0 again.
- R8: While `pwrDownN` is 0, the following hold:
  - `sdaOe` is 0 and bus activity is ignored.
  - `cfgRegs` is kept.
  - After `pwrDownN` returns to 1, nothing is acknowledged until a new START.
- R9: With the filter enabled (default), a pulse on either line that lasts fewer than 3 system-clock samples has no effect. It causes no extra bit and no false START.
- R10: After reset, `sdaOe` is 0, `xferValid` is 0 and all registers read 0.
- R11: The block has no clock output. It never drives data low during the eight data bits of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDownN | input | 1 | Active-low power-down; freezes the interface |
| sclIn | input | 1 | Bus clock line as received |
| sdaIn | input | 1 | Bus data line as received |
| sdaOe | output | 1 | 1 pulls the data line low (acknowledge) |
| xferValid | output | 1 | Transaction reached the end of the byte-count acknowledge |
| cfgRegs | output | NUM_REGS*8 | Configuration register bank, register 0 in the low byte |

## Verification
The assertions take several things for granted about the bus:
- it is driven by a well-behaved controller;
- data changes only while the clock is low, except for START and STOP;
- each bus-clock phase lasts many system-clock cycles, longer than the synchroniser and filter latency.

Under those conditions an acknowledge can begin only after a filtered clock fall, and can end only on a fall, a START, a STOP or power-down. The stimulus holds every quarter bit for 16 system cycles and changes data only in the middle of the low phase. Its one deliberate departure from these conditions is the glitch test, whose pulses last two samples and so fall below the filter threshold.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_DATA,
    ST_SKIP
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic wrEn;
    logic ptrClr;
  } dpStrobe_t;

  // filtered bus events, one system cycle wide
  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } busEvent_t;

endpackage

// File: rtl/smbus_line_cond.sv
module smbus_line_cond #(
  parameter bit FILTER_EN  = 1'b1,
  parameter int FILTER_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);

  localparam int CNT_W = $clog2(FILTER_LEN + 1);

  logic [1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], lineIn};
  end

  generate
    if (FILTER_EN) begin : g_filt
      logic [CNT_W-1:0] stableCnt;
      logic             filtQ;

      // accept a new level only after FILTER_LEN matching samples
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          filtQ     <= 1'b1;
          stableCnt <= '0;
        end else if (syncQ[1] == filtQ) begin
          stableCnt <= '0;
        end else if (stableCnt == CNT_W'(FILTER_LEN - 1)) begin
          filtQ     <= syncQ[1];
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end

      assign lineOut = filtQ;
    end else begin : g_pass
      assign lineOut = syncQ[1];
    end
  endgenerate

endmodule

// File: rtl/smbus_cfg_ctrl.sv
module smbus_cfg_ctrl
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDownN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t         strobe,
  output busEvent_t         busEv,
  output logic              sdaOe,
  output logic              xferValid
);

  busState_t  state;
  logic       prevScl, prevSda;
  logic [3:0] bitCnt;
  logic [1:0] byteIdx;   // 0 command, 1 count, 2 data (saturating)
  logic       afterAddr;
  logic       byteFull, addrHit;

  always_comb begin
    busEv.rise  = pwrDownN & sclF & ~prevScl;
    busEv.fall  = pwrDownN & ~sclF & prevScl;
    busEv.start = pwrDownN & sclF & prevScl & ~sdaF & prevSda;
    busEv.stop  = pwrDownN & sclF & prevScl & sdaF & ~prevSda;
  end

  assign byteFull = (bitCnt == 4'd8);
  assign addrHit  = (rxByte[7:1] == DEV_ADDR) && !rxByte[0] && (rxByte[7:1] != 7'd0);

  always_comb begin
    strobe.shiftEn = busEv.rise && !byteFull &&
                     ((state == ST_ADDR) || (state == ST_DATA));
    strobe.wrEn    = busEv.fall && byteFull && (state == ST_DATA) && (byteIdx == 2'd2);
    strobe.ptrClr  = busEv.start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      prevScl   <= 1'b1;
      prevSda   <= 1'b1;
      bitCnt    <= '0;
      byteIdx   <= '0;
      afterAddr <= 1'b0;
      sdaOe     <= 1'b0;
      xferValid <= 1'b0;
    end else begin
      prevScl <= sclF;
      prevSda <= sdaF;
      if (!pwrDownN) begin
        state  <= ST_IDLE;
        sdaOe  <= 1'b0;
        bitCnt <= '0;
      end else if (busEv.start) begin
        state     <= ST_ADDR;
        bitCnt    <= '0;
        byteIdx   <= '0;
        afterAddr <= 1'b1;
        sdaOe     <= 1'b0;
        xferValid <= 1'b0;
      end else if (busEv.stop) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        if (strobe.shiftEn) bitCnt <= bitCnt + 1'b1;
        if (busEv.fall) begin
          unique case (state)
            ST_ADDR: if (byteFull) begin
              if (addrHit) begin
                state <= ST_ACK;
                sdaOe <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_DATA: if (byteFull) begin
              state <= ST_ACK;
              sdaOe <= 1'b1;
            end
            ST_ACK: begin
              sdaOe  <= 1'b0;
              state  <= ST_DATA;
              bitCnt <= '0;
              if (!afterAddr) begin
                if (byteIdx == 2'd1) xferValid <= 1'b1;
                if (byteIdx != 2'd2) byteIdx <= byteIdx + 1'b1;
              end
              afterAddr <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/smbus_cfg_datapath.sv
module smbus_cfg_datapath
  import smbus_cfg_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sdaF,
  input  dpStrobe_t                  strobe,
  output logic [BYTE_W-1:0]          rxByte,
  output logic [NUM_REGS*BYTE_W-1:0] cfgRegs
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);

  logic [BYTE_W-1:0] shiftQ;
  logic [PTR_W-1:0]  wrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftQ <= '0;
    else if (strobe.shiftEn) shiftQ <= {shiftQ[BYTE_W-2:0], sdaF};
  end

  // pointer parks at NUM_REGS, which selects no register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wrPtr <= '0;
    else if (strobe.ptrClr) wrPtr <= '0;
    else if (strobe.wrEn && (wrPtr != PTR_W'(NUM_REGS))) wrPtr <= wrPtr + 1'b1;
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [BYTE_W-1:0] regQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regQ <= '0;
        else if (strobe.wrEn && (wrPtr == PTR_W'(i))) regQ <= shiftQ;
      end
      assign cfgRegs[i*BYTE_W +: BYTE_W] = regQ;
    end
  endgenerate

  assign rxByte = shiftQ;

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         NUM_REGS   = 4,
  parameter bit         FILTER_EN  = 1'b1,
  parameter int         FILTER_LEN = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pwrDownN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  output logic                       xferValid,
  output logic [NUM_REGS*BYTE_W-1:0] cfgRegs
);

  logic [1:0]        lineRaw, lineF;   // [0] clock, [1] data
  logic [BYTE_W-1:0] rxByte;
  dpStrobe_t         strobe;
  busEvent_t         busEv;

  assign lineRaw = {sdaIn, sclIn};

  generate
    for (genvar l = 0; l < 2; l++) begin : g_line
      smbus_line_cond #(.FILTER_EN(FILTER_EN), .FILTER_LEN(FILTER_LEN)) u_cond (
        .clk(clk), .rstN(rstN), .lineIn(lineRaw[l]), .lineOut(lineF[l])
      );
    end
  endgenerate

  smbus_cfg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN),
    .sclF(lineF[0]), .sdaF(lineF[1]), .rxByte(rxByte),
    .strobe(strobe), .busEv(busEv), .sdaOe(sdaOe), .xferValid(xferValid)
  );

  smbus_cfg_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .sdaF(lineF[1]), .strobe(strobe),
    .rxByte(rxByte), .cfgRegs(cfgRegs)
  );

endmodule

// File: rtl/smbus_cfg_checker.sv
module smbus_cfg_checker
  import smbus_cfg_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrDownN,
  input logic             sclF,
  input busEvent_t        busEv,
  input logic             sdaOe,
  input logic             xferValid,
  input logic [REG_W-1:0] cfgRegs
);

  // R3: acknowledge starts only right after a filtered clock fall
  p_ack_after_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(busEv.fall));

  // R3: acknowledge ends on a fall, START, STOP or power-down
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> $past(busEv.fall || busEv.start || busEv.stop || !pwrDownN));

  // R11: data is never pulled low while the clock is high at ack onset
  p_ack_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclF);

  // R8: power-down releases the data line
  p_pd_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |=> !sdaOe);

  // R8: power-down keeps the register bank
  p_pd_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |=> $stable(cfgRegs));

  // R6: a START clears the valid flag
  p_valid_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    busEv.start |=> !xferValid);

endmodule

bind smbus_cfg_slave smbus_cfg_checker #(.REG_W(NUM_REGS*8)) u_chk (
  .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN), .sclF(lineF[0]),
  .busEv(busEv), .sdaOe(sdaOe), .xferValid(xferValid), .cfgRegs(cfgRegs)
);

// File: tb/tb_smbus_cfg_slave.sv
module tb_smbus_cfg_slave;

  localparam int NREG = 4;
  localparam int Q    = 16;   // system cycles per quarter bit

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrDownN = 1'b1;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe, xferValid, sdaBus;
  logic [NREG*8-1:0] cfgRegs;

  int checks = 0;
  int fails = 0;
  int driveViol = 0;
  logic [7:0] expRegs [NREG];

  always #2 clk = ~clk;   // 250 MHz

  assign sdaBus = sdaDrv & ~sdaOe;

  smbus_cfg_slave dut (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN), .sclIn(sclDrv),
    .sdaIn(sdaBus), .sdaOe(sdaOe), .xferValid(xferValid), .cfgRegs(cfgRegs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  // glitchy=1 adds a 2-sample clock pulse and a 2-sample data dip in bit 4
  task automatic sendByteX(input logic [7:0] b, input bit glitchy, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ();
      if (glitchy && i == 4) begin
        sclDrv = 1'b1; repeat (2) @(negedge clk); sclDrv = 1'b0; waitQ();
      end
      sclDrv = 1'b1; waitQ();
      if (sdaOe) driveViol++;
      if (glitchy && i == 4 && b[i]) begin
        sdaDrv = 1'b0; repeat (2) @(negedge clk); sdaDrv = 1'b1;
      end
      waitQ();
      sclDrv = 1'b0; waitQ();
    end
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    ack = !sdaBus;
    waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    sendByteX(b, 1'b0, ack);
  endtask

  task automatic doWrite(input logic [7:0] addr, input int n,
                         input logic [7:0] d [8], output int acks);
    bit a;
    acks = 0;
    busStart();
    sendByte(addr, a); acks += int'(a);
    sendByte(8'h5C, a); acks += int'(a);
    sendByte(8'(n), a); acks += int'(a);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], a); acks += int'(a);
    end
    busStop();
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(req, 32'(cfgRegs[i*8 +: 8]), 32'(expRegs[i]));
  endtask

  task automatic tReset();
    chk("R10 sdaOe", 32'(sdaOe), 0);
    chk("R10 xferValid", 32'(xferValid), 0);
    chk("R10 cfgRegs", 32'(cfgRegs), 0);
  endtask

  task automatic tBasic();
    bit a;
    busStart();
    sendByte(8'hD2, a); chk("R1 address ack", 32'(a), 1);
    sendByte(8'h00, a); chk("R3 command ack", 32'(a), 1);
    chk("R6 not valid before count ack", 32'(xferValid), 0);
    sendByte(8'h02, a); chk("R3 count ack", 32'(a), 1);
    chk("R6 valid after count ack", 32'(xferValid), 1);
    sendByte(8'h11, a); chk("R3 data ack", 32'(a), 1);
    sendByte(8'h22, a); chk("R3 data ack", 32'(a), 1);
    busStop();
    expRegs[0] = 8'h11; expRegs[1] = 8'h22;
    checkRegs("R4 stored data");
  endtask

  task automatic tOverflow();
    logic [7:0] d [8];
    int acks;
    for (int i = 0; i < 8; i++) d[i] = 8'hA1 + 8'(i);
    doWrite(8'hD2, 6, d, acks);
    chk("R5 all bytes acked", 32'(acks), 9);
    for (int i = 0; i < NREG; i++) expRegs[i] = d[i];
    checkRegs("R5 extra bytes discarded");
  endtask

  task automatic tForeign();
    logic [7:0] d [8];
    int acks;
    for (int i = 0; i < 8; i++) d[i] = 8'h55;
    doWrite(8'hA0, 2, d, acks);
    chk("R2 other address", 32'(acks), 0);
    doWrite(8'hD3, 2, d, acks);
    chk("R2 read bit", 32'(acks), 0);
    doWrite(8'h00, 2, d, acks);
    chk("R2 general call", 32'(acks), 0);
    checkRegs("R2 no writes");
  endtask

  task automatic tRestart();
    bit a;
    busStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h03, a);
    sendByte(8'h31, a);
    busStart();
    chk("R6 cleared by repeated START", 32'(xferValid), 0);
    sendByte(8'hD2, a); chk("R7 address after repeated START", 32'(a), 1);
    sendByte(8'h00, a); sendByte(8'h01, a);
    sendByte(8'h41, a); chk("R7 data acked", 32'(a), 1);
    busStop();
    expRegs[0] = 8'h41;
    checkRegs("R7 restart writes from reg0");
  endtask

  task automatic tPowerDown();
    logic [7:0] d [8];
    int acks;
    bit a;
    for (int i = 0; i < 8; i++) d[i] = 8'h99 - 8'(i);
    pwrDownN = 1'b0; waitQ();
    doWrite(8'hD2, 2, d, acks);
    chk("R8 no ack in power-down", 32'(acks), 0);
    chk("R8 sdaOe released", 32'(sdaOe), 0);
    checkRegs("R8 registers kept");
    pwrDownN = 1'b1; waitQ();
    busStart();
    sendByte(8'hD2, a); sendByte(8'h00, a);
    pwrDownN = 1'b0; waitQ(); pwrDownN = 1'b1; waitQ();
    sendByte(8'h01, a); chk("R8 needs new START", 32'(a), 0);
    sendByte(8'h66, a);
    busStop();
    checkRegs("R8 mid-transfer power-down");
    d[0] = 8'h77;
    doWrite(8'hD2, 1, d, acks);
    chk("R8 works after release", 32'(acks), 4);
    expRegs[0] = 8'h77;
    checkRegs("R8 write after release");
  endtask

  task automatic tGlitch();
    bit a;
    busStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h02, a);
    sendByteX(8'h5A, 1'b1, a); chk("R9 glitched byte acked", 32'(a), 1);
    sendByte(8'h6B, a); chk("R9 next byte acked", 32'(a), 1);
    busStop();
    expRegs[0] = 8'h5A; expRegs[1] = 8'h6B;
    checkRegs("R9 glitches ignored");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) expRegs[i] = 8'h00;
    repeat (5) @(negedge clk);
    tReset();
    rstN = 1'b1;
    waitQ();
    tBasic();
    tOverflow();
    tForeign();
    tRestart();
    tPowerDown();
    tGlitch();
    chk("R11 no drive during data bits", 32'(driveViol), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule